// File: doc/BRIEF.md
# Accumulator ALU with Carry, Rotate and Skip

This block runs one register-to-register instruction per strobe on a small file of accumulators that share a single carry flag. Each instruction takes a source and a destination register and picks one of eight functions. The carry is first preset to one of four values. The raw result then passes through an optional 17-bit rotate through the carry, or through a byte swap. A condition on the final result and carry then asks for a skip. A no-load bit can throw the result away while the skip decision still stands.

The instruction is presented for one cycle with `valid_i` high. At the next rising edge the register file, the carry flag and the registered outputs all update together. `done_o` then marks the single cycle in which `result_o`, `carry_o` and `skip_o` describe that instruction. Instruction sequencing reads the skip signal, but the block only reports it.

Top module: `acc_alu`

## Requirements
- R1: A synchronous active-high reset clears all accumulators, the carry flag, `done_o`, `skip_o` and `result_o` to zero.
- R2: Function codes on `func_i` are 0 move, 1 complement, 2 negate, 3 increment source, 4 add, 5 subtract (destination minus source), 6 add-complement (NOT source plus destination), 7 AND. Negate and subtract are computed as complement plus one.
- R3: For the two-operand functions (4, 5, 6, 7), the second operand is the value held in the destination register before the instruction.
- R4: `cpre_i` sets the base carry before the operation: 0 keeps it, 1 clears it, 2 sets it, 3 inverts it.
- R5: A carry out of bit 15 from negate, increment, add, subtract or add-complement inverts the base carry. Move, complement and AND leave the base carry as it is.
- R6: `shift_i` = 1 rotates the 17-bit value {carry, result} left by one, and `shift_i` = 2 rotates it right by one. In both cases the carry sits between bit 15 and bit 0.
- R7: `shift_i` = 3 exchanges the upper and lower bytes of the result and leaves the carry untouched. `shift_i` = 0 applies no shift.
- R8: `test_i` chooses the skip condition, evaluated on the shifted result and final carry: 0 never, 1 always, 2 result zero, 3 result non-zero, 4 carry zero, 5 carry set, 6 carry zero or result zero, 7 carry set and result non-zero.
- R9: When `noload_i` is high, neither the destination register nor the carry flag changes. `result_o` and `skip_o` still report the computed value and the test outcome.
- R10: `done_o` is high for exactly the cycle after each strobe. Without a strobe, the registers and the carry hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Instruction strobe |
| src_i | input | 2 | Source register number |
| dst_i | input | 2 | Destination register number |
| func_i | input | 3 | Function code |
| cpre_i | input | 2 | Carry preset code |
| shift_i | input | 2 | Shift/swap code |
| test_i | input | 3 | Skip test code |
| noload_i | input | 1 | Discard result and carry |
| done_o | output | 1 | Result valid, one cycle after strobe |
| result_o | output | 16 | Shifted result of the instruction |
| carry_o | output | 1 | Carry flag |
| skip_o | output | 1 | Skip request of the instruction |

## Verification
The assertions assume that the inputs are stable and known while `valid_i` is high, and that no strobe arrives during reset. They also assume the carry flag is touched only by strobed instructions. The bench changes inputs only at falling edges and holds `valid_i` low through reset. Every register field it drives stays inside its declared encoding, so every code the assertions decode is legal.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [2:0] {
    F_MOV = 3'd0, F_COM = 3'd1, F_NEG = 3'd2, F_INC = 3'd3,
    F_ADD = 3'd4, F_SUB = 3'd5, F_ADC = 3'd6, F_AND = 3'd7
  } func_e;

  typedef enum logic [1:0] {
    C_KEEP = 2'd0, C_CLR = 2'd1, C_SET = 2'd2, C_INV = 2'd3
  } cpre_e;

  typedef enum logic [1:0] {
    S_NONE = 2'd0, S_ROL = 2'd1, S_ROR = 2'd2, S_SWAP = 2'd3
  } shift_e;

  typedef enum logic [2:0] {
    T_NEVER = 3'd0, T_ALWAYS = 3'd1, T_ZERO = 3'd2, T_NZERO = 3'd3,
    T_CZERO = 3'd4, T_CSET = 3'd5, T_EITHERZ = 3'd6, T_BOTHNZ = 3'd7
  } test_e;
endpackage

// File: rtl/acc_alu_regfile.sv
module acc_alu_regfile #(
  parameter int W = 16,
  parameter int N = 4,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/acc_alu_func.sv
module acc_alu_func
  import acc_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  func_e        func,
  input  cpre_e        cpre,
  input  logic         cy_now,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         cy
);
  logic [W:0] sum;
  logic       base;

  always_comb begin
    unique case (cpre)
      C_KEEP:  base = cy_now;
      C_CLR:   base = 1'b0;
      C_SET:   base = 1'b1;
      default: base = ~cy_now;
    endcase
  end

  always_comb begin
    unique case (func)
      F_MOV:   sum = {1'b0, a};
      F_COM:   sum = {1'b0, ~a};
      F_NEG:   sum = {1'b0, ~a} + (W+1)'(1);
      F_INC:   sum = {1'b0, a} + (W+1)'(1);
      F_ADD:   sum = {1'b0, a} + {1'b0, b};
      F_SUB:   sum = {1'b0, b} + {1'b0, ~a} + (W+1)'(1);
      F_ADC:   sum = {1'b0, b} + {1'b0, ~a};
      default: sum = {1'b0, a & b};
    endcase
  end

  assign res = sum[W-1:0];
  assign cy  = base ^ sum[W];
endmodule

// File: rtl/acc_alu_post.sv
module acc_alu_post
  import acc_alu_pkg::*;
#(
  parameter int W = 16,
  localparam int H = W / 2
) (
  input  shift_e       shift,
  input  test_e        test,
  input  logic [W-1:0] res_in,
  input  logic         cy_in,
  output logic [W-1:0] res_out,
  output logic         cy_out,
  output logic         skip
);
  logic zr;

  always_comb begin
    res_out = res_in;
    cy_out  = cy_in;
    unique case (shift)
      S_ROL: begin
        res_out = {res_in[W-2:0], cy_in};
        cy_out  = res_in[W-1];
      end
      S_ROR: begin
        res_out = {cy_in, res_in[W-1:1]};
        cy_out  = res_in[0];
      end
      S_SWAP:  res_out = {res_in[H-1:0], res_in[W-1:H]};
      default: ;
    endcase
  end

  assign zr = (res_out == '0);

  always_comb begin
    unique case (test)
      T_NEVER:   skip = 1'b0;
      T_ALWAYS:  skip = 1'b1;
      T_ZERO:    skip = zr;
      T_NZERO:   skip = !zr;
      T_CZERO:   skip = !cy_out;
      T_CSET:    skip = cy_out;
      T_EITHERZ: skip = !cy_out || zr;
      default:   skip = cy_out && !zr;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int W = 16,
  parameter int N = 4,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [2:0]    func_i,
  input  logic [1:0]    cpre_i,
  input  logic [1:0]    shift_i,
  input  logic [2:0]    test_i,
  input  logic          noload_i,
  output logic          done_o,
  output logic [W-1:0]  result_o,
  output logic          carry_o,
  output logic          skip_o
);
  logic [W-1:0] opa, opb, fres, pres;
  logic         fcy, pcy, pskip;
  logic         carry_q;

  acc_alu_regfile #(.W(W), .N(N)) u_rf (
    .clk(clk), .rst(rst),
    .we(valid_i && !noload_i), .waddr(dst_i), .wdata(pres),
    .raddr_a(src_i), .raddr_b(dst_i),
    .rdata_a(opa), .rdata_b(opb)
  );

  acc_alu_func #(.W(W)) u_func (
    .func(func_e'(func_i)), .cpre(cpre_e'(cpre_i)), .cy_now(carry_q),
    .a(opa), .b(opb), .res(fres), .cy(fcy)
  );

  acc_alu_post #(.W(W)) u_post (
    .shift(shift_e'(shift_i)), .test(test_e'(test_i)),
    .res_in(fres), .cy_in(fcy),
    .res_out(pres), .cy_out(pcy), .skip(pskip)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_q  <= 1'b0;
      done_o   <= 1'b0;
      result_o <= '0;
      skip_o   <= 1'b0;
    end else begin
      done_o <= valid_i;
      if (valid_i) begin
        result_o <= pres;
        skip_o   <= pskip;
        if (!noload_i) carry_q <= pcy;
      end
    end
  end

  assign carry_o = carry_q;

  p_done_follows_valid_r10: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> done_o);
  p_done_only_after_valid_r10: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> !done_o);
  p_idle_holds_carry_r10: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> $stable(carry_o));
  p_noload_holds_carry_r9: assert property (@(posedge clk) disable iff (rst)
    (valid_i && noload_i) |=> $stable(carry_o));
  p_always_skip_r8: assert property (@(posedge clk) disable iff (rst)
    (valid_i && test_i == T_ALWAYS) |=> skip_o);
  p_never_skip_r8: assert property (@(posedge clk) disable iff (rst)
    (valid_i && test_i == T_NEVER) |=> !skip_o);
  p_set_carry_logic_r4: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !noload_i && cpre_i == C_SET && shift_i == S_NONE &&
     (func_i == F_MOV || func_i == F_COM || func_i == F_AND)) |=> carry_o);
  p_swap_keeps_carry_r7: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !noload_i && cpre_i == C_KEEP && shift_i == S_SWAP &&
     (func_i == F_MOV || func_i == F_COM || func_i == F_AND)) |=> $stable(carry_o));
endmodule

// File: tb/acc_alu_bench.sv
module acc_alu_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_i = 1'b0;
  logic [1:0]  src_i = '0, dst_i = '0, cpre_i = '0, shift_i = '0;
  logic [2:0]  func_i = '0, test_i = '0;
  logic        noload_i = 1'b0;
  logic        done_o, carry_o, skip_o;
  logic [15:0] result_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  logic [15:0] m_reg [4];
  logic        m_cy;

  logic [15:0] q_res [$];
  logic        q_cy  [$];
  logic        q_sk  [$];
  string       q_tag [$];

  always #4 clk = ~clk;

  acc_alu u_acc_alu (
    .clk(clk), .rst(rst), .valid_i(valid_i), .src_i(src_i), .dst_i(dst_i),
    .func_i(func_i), .cpre_i(cpre_i), .shift_i(shift_i), .test_i(test_i),
    .noload_i(noload_i), .done_o(done_o), .result_o(result_o),
    .carry_o(carry_o), .skip_o(skip_o)
  );

  task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic op(input string tag, input int s, input int d, input int f,
                    input int cp, input int sh, input int t, input bit nl);
    logic        c;
    logic [16:0] v;
    logic [15:0] a, b, r;
    logic        z, sk;
    a = m_reg[s];
    b = m_reg[d];
    case (cp)
      1: c = 1'b0;
      2: c = 1'b1;
      3: c = !m_cy;
      default: c = m_cy;
    endcase
    case (f)
      0: v = {1'b0, a};
      1: v = {1'b0, ~a};
      2: v = 17'h10000 - {1'b0, a};
      3: v = {1'b0, a} + 17'd1;
      4: v = {1'b0, a} + {1'b0, b};
      5: v = {1'b0, b} + 17'h10000 - {1'b0, a};
      6: v = {1'b0, b} + {1'b0, 16'hffff - a};
      default: v = {1'b0, a & b};
    endcase
    if (v[16]) c = !c;
    r = v[15:0];
    case (sh)
      1: begin {c, r} = {r, c}; end
      2: begin {r, c} = {c, r}; end
      3: r = {r[7:0], r[15:8]};
      default: ;
    endcase
    z = (r == 16'h0);
    case (t)
      0: sk = 0;
      1: sk = 1;
      2: sk = z;
      3: sk = !z;
      4: sk = !c;
      5: sk = c;
      6: sk = !c || z;
      default: sk = c && !z;
    endcase
    if (!nl) begin
      m_reg[d] = r;
      m_cy = c;
    end
    q_res.push_back(r);
    q_cy.push_back(m_cy);
    q_sk.push_back(sk);
    q_tag.push_back(tag);
    src_i = 2'(s); dst_i = 2'(d); func_i = 3'(f); cpre_i = 2'(cp);
    shift_i = 2'(sh); test_i = 3'(t); noload_i = nl; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  always @(negedge clk) begin
    if (!rst && done_o) begin
      if (q_res.size() == 0) begin
        checks++; failures++;
        $display("FAIL R10 done without strobe actual=1 expected=0");
      end else begin
        string tg;
        tg = q_tag.pop_front();
        check(tg, "result", result_o, q_res.pop_front());
        check(tg, "carry", {15'd0, carry_o}, {15'd0, q_cy.pop_front()});
        check(tg, "skip", {15'd0, skip_o}, {15'd0, q_sk.pop_front()});
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) m_reg[i] = '0;
    m_cy = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state of outputs
    check("R1", "done", {15'd0, done_o}, 16'd0);
    check("R1", "carry", {15'd0, carry_o}, 16'd0);
    check("R1", "skip", {15'd0, skip_o}, 16'd0);
    check("R1", "result", result_o, 16'd0);
    op("R1", 2, 3, 0, 0, 0, 2, 0);          // move of a cleared register, skip on zero
    // R2 functions
    op("R2", 0, 0, 1, 0, 0, 3, 0);          // r0 = FFFF
    op("R2 R5", 0, 1, 3, 0, 0, 2, 0);       // r1 = 0, carry toggles
    op("R2 R5", 1, 2, 2, 1, 0, 5, 0);       // negate zero: carry out
    op("R2", 0, 2, 2, 1, 0, 4, 0);          // r2 = 1
    op("R3 R5", 0, 2, 4, 1, 0, 7, 0);       // FFFF + 1
    op("R3", 2, 0, 5, 0, 0, 6, 0);          // r0 - r2
    op("R3", 0, 2, 6, 2, 0, 3, 0);
    op("R3", 0, 2, 7, 3, 0, 7, 0);
    // R4 carry presets
    op("R4", 0, 3, 0, 2, 0, 5, 0);
    op("R4", 0, 3, 0, 3, 0, 5, 0);
    op("R4", 0, 3, 0, 0, 0, 4, 0);
    op("R4", 0, 3, 0, 1, 0, 4, 0);
    // R6 rotates, R7 swap
    op("R6", 0, 1, 0, 2, 1, 5, 0);
    op("R6", 1, 1, 0, 0, 2, 2, 0);
    op("R6", 0, 2, 3, 1, 2, 5, 0);
    op("R7", 0, 3, 3, 2, 3, 6, 0);
    op("R7", 3, 3, 1, 1, 3, 3, 0);
    // R9 no-load: then read back destination and carry
    op("R9", 0, 1, 1, 3, 1, 1, 1);
    op("R9", 1, 1, 0, 0, 0, 2, 0);
    // R10 idle gap
    repeat (5) @(negedge clk);
    op("R10", 2, 2, 0, 0, 0, 0, 0);
    for (int k = 0; k < 400; k++) begin
      op("R2 R4 R5 R6 R7 R8 R9", int'($urandom_range(3)), int'($urandom_range(3)),
         int'($urandom_range(7)), int'($urandom_range(3)), int'($urandom_range(3)),
         int'($urandom_range(7)), ($urandom_range(3) == 0));
      if ($urandom_range(7) == 0) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    if (q_res.size() != 0) begin
      checks++; failures++;
      $display("FAIL R10 missing done actual=%0d expected=0", q_res.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule